// File: doc/BRIEF.md
# Software-Generated Interrupt Acceptance Filter

This block sits between the fabric that delivers software-generated interrupt requests and one processor's interrupt state. Each request names one of sixteen interrupts, the group the sender asked for, and whether the sender runs in the non-secure world. The block compares the request with the group configured for that interrupt and with a per-interrupt permission level. It then either accepts the request, which sets the interrupt's pending bit, or rejects it and gives a reason code.

Group matching takes place first. A group-1 request aimed at an interrupt configured as group 0 is treated as a group-0 request. Any group that is still different after this adjustment causes a rejection. When security is enabled and the sender is non-secure, a 2-bit permission level per interrupt must also reach a threshold that depends on the interrupt's group. The decision is registered: the accept pulse or the reject pulse, and the pending bit, all appear on the clock edge that samples the request. One request can be taken every cycle.

Top module: `sgi_filt`

## Requirements
- R1: After reset, `acc_vld`, `rej_vld`, `acc_idx`, `rej_why` and every bit of `pend` are zero.
- R2: The permission level of interrupt n is `perm_word[2n+1:2n]`. Fields of the other interrupts play no part in the decision for n.
- R3: A group-1 request (`req_grp`=1) to an interrupt whose `cfg_grp` is 0 is handled as a group-0 request and can be accepted.
- R4: A group-0 request to an interrupt whose `cfg_grp` is 1 is rejected with `rej_why`=0 (group mismatch). This holds even when the sender is secure or security is disabled.
- R5: A non-secure request (`req_ns`=1) with `sec_off`=0 to a group-0 interrupt is accepted only if the permission level is 1 or more. Otherwise it is rejected with `rej_why`=1.
- R6: A non-secure request with `sec_off`=0 to a group-1 interrupt is accepted only if the permission level is 2 or more. Otherwise it is rejected with `rej_why`=1.
- R7: The permission level is not examined when `req_ns`=0 or `sec_off`=1.
- R8: A request sampled with `req_vld`=1 on a clock edge produces, from that edge, exactly one of `acc_vld` or `rej_vld` high for one cycle. `acc_idx` equals the request number when `acc_vld` is high.
- R9: When a request fails both the group check and the permission check, it is rejected with `rej_why`=0.
- R10: An accepted request sets `pend[req_num]` on the same edge that raises `acc_vld`. Pending bits are never cleared except by reset, and a rejected request leaves `pend` unchanged.
- R11: An edge with `req_vld`=0 raises neither pulse and leaves `pend` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vld | input | 1 | Request strobe |
| req_num | input | 4 | Target interrupt number |
| req_grp | input | 1 | Requested group (0 or 1) |
| req_ns | input | 1 | Request comes from the non-secure world |
| cfg_grp | input | 1 | Configured group of the target interrupt |
| sec_off | input | 1 | Security disabled |
| perm_word | input | 32 | Sixteen 2-bit non-secure permission levels |
| acc_vld | output | 1 | Accept pulse |
| acc_idx | output | 4 | Number of the accepted interrupt |
| rej_vld | output | 1 | Reject pulse |
| rej_why | output | 2 | Reject reason: 0 group mismatch, 1 insufficient permission |
| pend | output | 16 | Pending bits |

## Verification
The table sweeps each combination of requested group and configured group, so the downgrade path can be told apart from a true mismatch. It tries every permission level against both thresholds, which exposes an off-by-one in the group-0 or group-1 limit. In each vector, the fields of the other interrupts in the permission word hold the complement of the target's field, so reading the wrong slot flips the result. Secure senders and the security-disabled input are each paired with a zero permission level, which shows that the check is bypassed. A request that fails both checks separates the two reason codes. Directed tests cover the reset state, idle cycles, back-to-back requests, and the stickiness of the pending bits.

// File: rtl/sgi_filt_pkg.sv
package sgi_filt_pkg;
  localparam int unsigned NUM_SGI = 16;
  localparam int unsigned PERM_W  = 2;
  localparam int unsigned IDX_W   = $clog2(NUM_SGI);
  localparam int unsigned WORD_W  = NUM_SGI * PERM_W;

  typedef enum logic [1:0] {
    WHY_GROUP = 2'd0,
    WHY_PERM  = 2'd1
  } why_e;

  // Group after the downgrade rule: group 1 folds onto group 0 targets.
  function automatic logic eff_group(input logic asked, input logic cfg);
    return asked & cfg;
  endfunction

  // Minimum permission level for a non-secure sender.
  function automatic logic [PERM_W-1:0] perm_need(input logic cfg);
    return cfg ? PERM_W'(2) : PERM_W'(1);
  endfunction

  function automatic logic [PERM_W-1:0] perm_of(input logic [WORD_W-1:0] w,
                                                input logic [IDX_W-1:0] n);
    return w[n*PERM_W +: PERM_W];
  endfunction
endpackage

// File: rtl/sgi_filt_decide.sv
module sgi_filt_decide
  import sgi_filt_pkg::*;
(
  input  logic              req_vld,
  input  logic [IDX_W-1:0]  req_num,
  input  logic              req_grp,
  input  logic              req_ns,
  input  logic              cfg_grp,
  input  logic              sec_off,
  input  logic [WORD_W-1:0] perm_word,
  output logic              take,
  output logic              drop,
  output why_e              why
);
  logic grp_bad;
  logic perm_chk;
  logic perm_bad;
  logic [PERM_W-1:0] lvl;

  always_comb begin
    grp_bad  = (eff_group(req_grp, cfg_grp) != cfg_grp);
    lvl      = perm_of(perm_word, req_num);
    perm_chk = req_ns & ~sec_off;
    perm_bad = perm_chk & (lvl < perm_need(cfg_grp));
    take     = req_vld & ~grp_bad & ~perm_bad;
    drop     = req_vld & (grp_bad | perm_bad);
    why      = grp_bad ? WHY_GROUP : WHY_PERM;
  end
endmodule

// File: rtl/sgi_filt_pend.sv
module sgi_filt_pend
  import sgi_filt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic [IDX_W-1:0]   set_idx,
  output logic [NUM_SGI-1:0] pend
);
  for (genvar g = 0; g < NUM_SGI; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend[g] <= 1'b0;
      else if (set_en && set_idx == IDX_W'(g)) pend[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/sgi_filt.sv
module sgi_filt
  import sgi_filt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_vld,
  input  logic [3:0]  req_num,
  input  logic        req_grp,
  input  logic        req_ns,
  input  logic        cfg_grp,
  input  logic        sec_off,
  input  logic [31:0] perm_word,
  output logic        acc_vld,
  output logic [3:0]  acc_idx,
  output logic        rej_vld,
  output logic [1:0]  rej_why,
  output logic [15:0] pend
);
  logic take;
  logic drop;
  why_e why;

  sgi_filt_decide u_decide (
    .req_vld(req_vld), .req_num(req_num), .req_grp(req_grp), .req_ns(req_ns),
    .cfg_grp(cfg_grp), .sec_off(sec_off), .perm_word(perm_word),
    .take(take), .drop(drop), .why(why)
  );

  sgi_filt_pend u_pend (
    .clk(clk), .rst_n(rst_n), .set_en(take), .set_idx(req_num), .pend(pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_vld <= 1'b0;
      acc_idx <= '0;
      rej_vld <= 1'b0;
      rej_why <= '0;
    end else begin
      acc_vld <= take;
      rej_vld <= drop;
      if (take) acc_idx <= req_num;
      if (drop) rej_why <= why;
    end
  end

  a_r8_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_vld && rej_vld));
  a_r8_answer: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> (acc_vld || rej_vld));
  a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> (!acc_vld && !rej_vld && $stable(pend)));
  a_r10_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld |-> pend[acc_idx]);
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(pend)) == $past(pend)));
  a_r9_code: assert property (@(posedge clk) disable iff (!rst_n)
    rej_vld |-> (rej_why <= 2'd1));
endmodule

// File: tb/sgi_filt_tb.sv
module sgi_filt_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_vld = 1'b0;
  logic [3:0] req_num = '0;
  logic req_grp = 1'b0, req_ns = 1'b0, cfg_grp = 1'b0, sec_off = 1'b0;
  logic [31:0] perm_word = '0;
  logic acc_vld, rej_vld;
  logic [3:0] acc_idx;
  logic [1:0] rej_why;
  logic [15:0] pend;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [15:0] exp_pend = '0;

  always #10 clk = ~clk;

  sgi_filt u_dut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_num(req_num),
    .req_grp(req_grp), .req_ns(req_ns), .cfg_grp(cfg_grp), .sec_off(sec_off),
    .perm_word(perm_word), .acc_vld(acc_vld), .acc_idx(acc_idx),
    .rej_vld(rej_vld), .rej_why(rej_why), .pend(pend)
  );

  // {num[11:8], grp[7], ns[6], cfg[5], off[4], perm[3:2], expect[1:0]}
  // expect: 0 accept, 1 reject group, 2 reject permission
  localparam int NV = 16;
  localparam logic [11:0] VEC [NV] = '{
    12'h380, 12'h52D, 12'h561, 12'h242, 12'h244, 12'h7E6, 12'h7E8, 12'h9EC,
    12'hAC4, 12'hBC2, 12'hCF0, 12'hD50, 12'hFA0, 12'h000, 12'hE7D, 12'h64C
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic fill(input logic [3:0] n, input logic [1:0] p);
    logic [31:0] w;
    w = {16{~p}};
    w[n*2 +: 2] = p;
    perm_word = w;
  endtask

  // Drive at a falling edge, the next rising edge samples, check at the next falling edge.
  task automatic send(input logic [3:0] n, input logic g, input logic ns,
                      input logic c, input logic off, input logic [1:0] p);
    req_vld = 1'b1; req_num = n; req_grp = g; req_ns = ns;
    cfg_grp = c; sec_off = off; fill(n, p);
    @(negedge clk);
    req_vld = 1'b0;
  endtask

  task automatic expect_out(input logic [1:0] e, input logic [3:0] n, input string req);
    if (e == 2'd0) begin
      exp_pend[n] = 1'b1;
      check(acc_vld && !rej_vld, req, "accept pulse", {acc_vld, rej_vld}, 2'b10);
      check(acc_idx == n, req, "accept index", acc_idx, n);
    end else begin
      check(rej_vld && !acc_vld, req, "reject pulse", {acc_vld, rej_vld}, 2'b01);
      check(rej_why == e - 2'd1, req, "reject reason", rej_why, e - 2'd1);
    end
    check(pend == exp_pend, "R10", "pending", pend, exp_pend);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    check(!acc_vld && !rej_vld && acc_idx == 0 && rej_why == 0 && pend == 0,
          "R1", "reset outputs", {acc_vld, rej_vld, acc_idx, rej_why, pend}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table: covers R2 R3 R4 R5 R6 R7 R9
    for (int i = 0; i < NV; i++) begin
      logic [11:0] v;
      v = VEC[i];
      send(v[11:8], v[7], v[6], v[5], v[4], v[3:2]);
      expect_out(v[1:0], v[11:8], $sformatf("R2-table vector %0d", i));
    end

    // R11: idle cycles leave outputs quiet and pend unchanged
    repeat (3) begin
      @(negedge clk);
      check(!acc_vld && !rej_vld, "R11", "idle pulse", {acc_vld, rej_vld}, 0);
      check(pend == exp_pend, "R11", "idle pending", pend, exp_pend);
    end

    // R8: back-to-back requests, one accept then one reject
    req_vld = 1'b1; req_num = 4'd4; req_grp = 1'b1; req_ns = 1'b0;
    cfg_grp = 1'b1; sec_off = 1'b0; fill(4'd4, 2'd0);
    @(negedge clk);
    exp_pend[4] = 1'b1;
    check(acc_vld && acc_idx == 4'd4 && !rej_vld, "R8", "first of pair",
          {acc_vld, rej_vld, acc_idx}, {2'b10, 4'd4});
    req_num = 4'd8; req_grp = 1'b0; cfg_grp = 1'b1;
    @(negedge clk);
    req_vld = 1'b0;
    check(rej_vld && !acc_vld && rej_why == 2'd0, "R8", "second of pair",
          {acc_vld, rej_vld, rej_why}, {2'b01, 2'd0});
    check(pend == exp_pend, "R10", "reject leaves pend", pend, exp_pend);
    @(negedge clk);
    check(!acc_vld && !rej_vld, "R8", "pulse one cycle", {acc_vld, rej_vld}, 0);

    // R10: accepting an already pending interrupt keeps it set
    send(4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0);
    expect_out(2'd0, 4'd3, "R10 repeat");

    // R1: reset mid-run clears pending
    rst_n = 1'b0;
    @(negedge clk);
    exp_pend = '0;
    check(pend == 0 && !acc_vld, "R1", "reset clears", pend, 0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule